// File: doc/BRIEF.md
# Floating-point special operand propagator

This block sits ahead of the finite datapath of a binary64 adder and multiplier. It looks at the two operands and sorts each one into a class. When at least one of them is not an ordinary number, it forms the final result itself, so the finite path is not used for that operation. An all-ones exponent marks a special value. The two most significant fraction bits give its kind: signalling NaN, quiet NaN, a missing-value marker called None, or infinity. The fraction bits below those two form a payload. The block carries the payload through to the result.

The None kind stands for a missing value. It acts as the identity of the operation, so it drops out of the result rather than poisoning it. Adding None returns the other operand, and multiplying by None acts like multiplying by one. NaNs win over None, and None wins over infinity. The invalid flag is raised in three cases: a signalling operand, infinity minus infinity, and infinity times zero. When both operands are ordinary, the downstream finite logic uses its own result and ignores this block's output. The result passes through a parameter-selected output register, which is one cycle deep by default.

Top module: `fpsp_top`

## Requirements
- R1: An operand whose exponent field is all ones is special. Its fraction bits [51:50] give the kind: 2'b11 signalling NaN, 2'b10 quiet NaN, 2'b01 None, 2'b00 infinity. An all-zero exponent with an all-zero fraction is zero. Every other encoding is finite.
- R2: One cycle after the inputs are presented, `spec_valid` is 1 exactly when at least one operand is special. When both operands are zero or finite, `spec_valid` and `invalid_flag` are both 0.
- R3: When exactly one operand is a NaN, the result is that operand, bit for bit. This holds whatever the other operand is, including None and infinity.
- R4: When both operands are NaNs, the result takes the sign and payload of `opnd_a`, with the kind set to quiet (2'b10).
- R5: `invalid_flag` is 1 whenever either operand is a signalling NaN.
- R6: When exactly one operand is None and the other is not a NaN, the result is the other operand, bit for bit, for both add (`op_mul`=0) and multiply (`op_mul`=1).
- R7: When both operands are None, the result is `opnd_a`, bit for bit.
- R8: In an add with no NaN or None operand, two infinities of opposite sign give the default quiet NaN 64'h7FF8_0000_0000_0000 and raise `invalid_flag`. Any other add involving an infinity returns the infinite operand bit for bit, taking `opnd_a` when both operands are infinite.
- R9: In a multiply, an infinity times a zero of either sign gives the default quiet NaN 64'h7FF8_0000_0000_0000 and raises `invalid_flag`.
- R10: In a multiply where an infinity meets a nonzero operand that is not a NaN or None, the result is infinite. Its sign is the XOR of the two operand signs, and its payload comes from the infinite operand (from `opnd_a` when both are infinite).
- R11: While `rst_n` is low, `spec_valid`, `spec_result` and `invalid_flag` are all 0.
- R12: `invalid_flag` stays 0 in every case not named in R5, R8 or R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mul | input | 1 | Operation select: 0 add, 1 multiply |
| opnd_a | input | 64 | First operand, binary64 |
| opnd_b | input | 64 | Second operand, binary64 |
| spec_valid | output | 1 | Result is produced by this block |
| spec_result | output | 64 | Special-case result |
| invalid_flag | output | 1 | Invalid-operation indication |

## Verification
The operand pairs cover each kind on its own against ordinary numbers, zeros of both signs and a denormal. This separates the special classes from the finite and zero classes. Mixed pairs are included on purpose: NaN with None, NaN with infinity, None with infinity, and two NaNs of different kinds. These show whether the precedence order is right and which operand's payload survives. Infinity pairs are run with equal and opposite signs, and against zero and against nonzero values, in both operations. This separates the invalid results from sign-combining propagation. Distinct payloads on every special constant make it possible to tell which operand was forwarded.

// File: rtl/fpsp_pkg.sv
package fpsp_pkg;

   // Operand classes produced by the classifier
   typedef enum logic [2:0] {
      CLS_FINITE = 3'd0,
      CLS_ZERO   = 3'd1,
      CLS_INF    = 3'd2,
      CLS_NONE   = 3'd3,
      CLS_QNAN   = 3'd4,
      CLS_SNAN   = 3'd5
   } fp_class_e;

   // Kind codes held in the top two fraction bits of an all-ones exponent (R1)
   localparam logic [1:0] KIND_SNAN = 2'b11;
   localparam logic [1:0] KIND_QNAN = 2'b10;
   localparam logic [1:0] KIND_NONE = 2'b01;
   localparam logic [1:0] KIND_INF  = 2'b00;

   function automatic logic cls_is_nan(input fp_class_e c);
      return (c == CLS_QNAN) || (c == CLS_SNAN);
   endfunction

   function automatic logic cls_is_special(input fp_class_e c);
      return (c != CLS_FINITE) && (c != CLS_ZERO);
   endfunction

endpackage

// File: rtl/fpsp_classify.sv
module fpsp_classify
   import fpsp_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
   input  logic [WORD_W-1:0] opnd,
   output fp_class_e         cls
);

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic [1:0]        kind;
   logic              exp_ones;
   logic              exp_zero;
   logic              frac_zero;

   assign exp_f     = opnd[WORD_W-2 -: EXP_W];
   assign frac_f    = opnd[FRAC_W-1:0];
   assign kind      = frac_f[FRAC_W-1 -: 2];
   assign exp_ones  = &exp_f;
   assign exp_zero  = ~|exp_f;
   assign frac_zero = ~|frac_f;

   // R1: kind decode on an all-ones exponent
   always_comb begin
      if (exp_ones) begin
         unique case (kind)
            KIND_SNAN: cls = CLS_SNAN;
            KIND_QNAN: cls = CLS_QNAN;
            KIND_NONE: cls = CLS_NONE;
            default:   cls = CLS_INF;
         endcase
      end else if (exp_zero && frac_zero) begin
         cls = CLS_ZERO;
      end else begin
         cls = CLS_FINITE;
      end
   end

endmodule

// File: rtl/fpsp_resolve.sv
module fpsp_resolve
   import fpsp_pkg::*;
#(
   parameter int EXP_W  = 11,
   parameter int FRAC_W = 52,
   localparam int WORD_W = 1 + EXP_W + FRAC_W,
   localparam int PAY_W  = FRAC_W - 2
) (
   input  logic              op_mul,
   input  logic [WORD_W-1:0] a,
   input  logic [WORD_W-1:0] b,
   input  fp_class_e         cls_a,
   input  fp_class_e         cls_b,
   output logic              res_valid,
   output logic [WORD_W-1:0] res_word,
   output logic              res_invalid
);

   localparam logic [WORD_W-1:0] DEFAULT_QNAN =
      {1'b0, {EXP_W{1'b1}}, KIND_QNAN, {PAY_W{1'b0}}};

   logic nan_a, nan_b, non_a, non_b, inf_a, inf_b, zro_a, zro_b;
   logic any_snan;
   logic sign_x;
   logic [WORD_W-1:0] inf_src;
   logic [WORD_W-1:0] quiet_a;

   assign nan_a    = cls_is_nan(cls_a);
   assign nan_b    = cls_is_nan(cls_b);
   assign non_a    = (cls_a == CLS_NONE);
   assign non_b    = (cls_b == CLS_NONE);
   assign inf_a    = (cls_a == CLS_INF);
   assign inf_b    = (cls_b == CLS_INF);
   assign zro_a    = (cls_a == CLS_ZERO);
   assign zro_b    = (cls_b == CLS_ZERO);
   assign any_snan = (cls_a == CLS_SNAN) || (cls_b == CLS_SNAN);
   assign sign_x   = a[WORD_W-1] ^ b[WORD_W-1];
   assign inf_src  = inf_a ? a : b;
   assign quiet_a  = {a[WORD_W-1], {EXP_W{1'b1}}, KIND_QNAN, a[PAY_W-1:0]};

   // R2: this block owns the result whenever either operand is special
   assign res_valid = cls_is_special(cls_a) || cls_is_special(cls_b);

   // Precedence: NaN, then None, then infinity
   always_comb begin
      res_word    = '0;
      res_invalid = any_snan;                       // R5
      if (nan_a && nan_b) begin
         res_word = quiet_a;                        // R4
      end else if (nan_a) begin
         res_word = a;                              // R3
      end else if (nan_b) begin
         res_word = b;                              // R3
      end else if (non_a && non_b) begin
         res_word = a;                              // R7
      end else if (non_a) begin
         res_word = b;                              // R6
      end else if (non_b) begin
         res_word = a;                              // R6
      end else if (inf_a || inf_b) begin
         if (!op_mul) begin
            if (inf_a && inf_b && sign_x) begin
               res_word    = DEFAULT_QNAN;          // R8
               res_invalid = 1'b1;
            end else begin
               res_word = inf_src;                  // R8
            end
         end else begin
            if ((inf_a && zro_b) || (zro_a && inf_b)) begin
               res_word    = DEFAULT_QNAN;          // R9
               res_invalid = 1'b1;
            end else begin
               res_word = {sign_x, inf_src[WORD_W-2:0]};   // R10
            end
         end
      end
   end

endmodule

// File: rtl/fpsp_outstage.sv
module fpsp_outstage #(
   parameter int WORD_W  = 64,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              d_valid,
   input  logic [WORD_W-1:0] d_word,
   input  logic              d_invalid,
   output logic              q_valid,
   output logic [WORD_W-1:0] q_word,
   output logic              q_invalid
);

   generate
      if (OUT_REG) begin : g_reg
         // R11: reset clears the registered outputs
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q_valid   <= 1'b0;
               q_word    <= '0;
               q_invalid <= 1'b0;
            end else begin
               q_valid   <= d_valid;
               q_word    <= d_valid ? d_word : '0;
               q_invalid <= d_invalid;
            end
         end
      end else begin : g_comb
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign q_valid   = rst_n & d_valid;
         assign q_word    = (rst_n & d_valid) ? d_word : '0;
         assign q_invalid = rst_n & d_invalid;
      end
   endgenerate

endmodule

// File: rtl/fpsp_top.sv
module fpsp_top
   import fpsp_pkg::*;
#(
   parameter int EXP_W   = 11,
   parameter int FRAC_W  = 52,
   parameter bit OUT_REG = 1'b1,
   localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_mul,
   input  logic [WORD_W-1:0] opnd_a,
   input  logic [WORD_W-1:0] opnd_b,
   output logic              spec_valid,
   output logic [WORD_W-1:0] spec_result,
   output logic              invalid_flag
);

   localparam int N_OPND = 2;

   // Elaboration-time parameter checks
   if (FRAC_W < 3) begin : g_bad_frac
      $error("fpsp_top: FRAC_W must leave room for two kind bits and a payload");
   end
   if (EXP_W < 2) begin : g_bad_exp
      $error("fpsp_top: EXP_W must be at least 2");
   end

   logic [WORD_W-1:0] opnd [N_OPND];
   fp_class_e         cls  [N_OPND];

   assign opnd[0] = opnd_a;
   assign opnd[1] = opnd_b;

   // One classifier per operand (R1)
   for (genvar gi = 0; gi < N_OPND; gi++) begin : g_cls
      fpsp_classify #(
         .EXP_W  (EXP_W),
         .FRAC_W (FRAC_W)
      ) u_cls (
         .opnd (opnd[gi]),
         .cls  (cls[gi])
      );
   end

   logic              r_valid;
   logic [WORD_W-1:0] r_word;
   logic              r_invalid;

   fpsp_resolve #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W)
   ) u_res (
      .op_mul      (op_mul),
      .a           (opnd_a),
      .b           (opnd_b),
      .cls_a       (cls[0]),
      .cls_b       (cls[1]),
      .res_valid   (r_valid),
      .res_word    (r_word),
      .res_invalid (r_invalid)
   );

   fpsp_outstage #(
      .WORD_W  (WORD_W),
      .OUT_REG (OUT_REG)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .d_valid   (r_valid),
      .d_word    (r_word),
      .d_invalid (r_invalid),
      .q_valid   (spec_valid),
      .q_word    (spec_result),
      .q_invalid (invalid_flag)
   );

endmodule

// File: rtl/fpsp_chk.sv
module fpsp_chk #(
   parameter int EXP_W   = 11,
   parameter int FRAC_W  = 52,
   parameter bit OUT_REG = 1'b1,
   localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              op_mul,
   input logic [WORD_W-1:0] opnd_a,
   input logic [WORD_W-1:0] opnd_b,
   input logic              spec_valid,
   input logic [WORD_W-1:0] spec_result,
   input logic              invalid_flag
);

   localparam logic [WORD_W-1:0] DQN =
      {1'b0, {EXP_W{1'b1}}, 2'b10, {(FRAC_W-2){1'b0}}};

   function automatic logic spc(input logic [WORD_W-1:0] w);
      return &w[WORD_W-2 -: EXP_W];
   endfunction
   function automatic logic knd(input logic [WORD_W-1:0] w, input logic [1:0] k);
      return spc(w) && (w[FRAC_W-1 -: 2] == k);
   endfunction

   // Operands aligned with the outputs they produced
   logic              o_mul;
   logic [WORD_W-1:0] o_a, o_b;

   generate
      if (OUT_REG) begin : g_lat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               o_mul <= 1'b0;
               o_a   <= '0;
               o_b   <= '0;
            end else begin
               o_mul <= op_mul;
               o_a   <= opnd_a;
               o_b   <= opnd_b;
            end
         end
         AST_RESET_CLEAR: assert property (@(posedge clk)
            !rst_n |-> (!spec_valid && !invalid_flag && spec_result == '0)); // R11
      end else begin : g_now
         assign o_mul = op_mul;
         assign o_a   = opnd_a;
         assign o_b   = opnd_b;
      end
   endgenerate

   logic nan_a, nan_b, non_a, non_b, sn_any, ord_both;
   assign nan_a    = knd(o_a, 2'b11) || knd(o_a, 2'b10);
   assign nan_b    = knd(o_b, 2'b11) || knd(o_b, 2'b10);
   assign non_a    = knd(o_a, 2'b01);
   assign non_b    = knd(o_b, 2'b01);
   assign sn_any   = knd(o_a, 2'b11) || knd(o_b, 2'b11);
   assign ord_both = !spc(o_a) && !spc(o_b);

   AST_ORDINARY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ord_both |-> (!spec_valid && !invalid_flag)); // R2
   AST_SPECIAL_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
      !ord_both |-> spec_valid); // R2
   AST_LONE_NAN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (nan_a != nan_b) |-> (spec_result == (nan_a ? o_a : o_b))); // R3
   AST_PAIR_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (nan_a && nan_b) |-> (spec_result[FRAC_W-1 -: 2] == 2'b10 &&
                            spec_result[WORD_W-1] == o_a[WORD_W-1])); // R4
   AST_SNAN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
      sn_any |-> invalid_flag); // R5
   AST_NONE_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
      (non_a && !non_b && !nan_b) |-> (spec_result == o_b)); // R6
   AST_NONE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (non_a && non_b) |-> (spec_result == o_a)); // R7
   AST_INVALID_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (invalid_flag && !sn_any) |-> (spec_result == DQN)); // R8
   AST_MUL_NO_ADD_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      (o_mul && !sn_any && !nan_a && !nan_b && spc(o_a) && spc(o_b)) |-> !invalid_flag); // R12

endmodule

bind fpsp_top fpsp_chk #(
   .EXP_W   (EXP_W),
   .FRAC_W  (FRAC_W),
   .OUT_REG (OUT_REG)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .op_mul       (op_mul),
   .opnd_a       (opnd_a),
   .opnd_b       (opnd_b),
   .spec_valid   (spec_valid),
   .spec_result  (spec_result),
   .invalid_flag (invalid_flag)
);

// File: tb/fpsp_top_tb.sv
module fpsp_top_tb;

   localparam logic [63:0] ONE    = 64'h3FF0_0000_0000_0000;
   localparam logic [63:0] TWO_N  = 64'hC000_0000_0000_0000;
   localparam logic [63:0] ZER_P  = 64'h0000_0000_0000_0000;
   localparam logic [63:0] ZER_N  = 64'h8000_0000_0000_0000;
   localparam logic [63:0] DEN    = 64'h0000_0000_0000_0001;
   localparam logic [63:0] INF_P  = 64'h7FF0_0000_0000_0007;
   localparam logic [63:0] INF_P0 = 64'h7FF0_0000_0000_0000;
   localparam logic [63:0] INF_N  = 64'hFFF0_0000_0000_0009;
   localparam logic [63:0] QN_A   = 64'h7FF8_0000_0000_1234;
   localparam logic [63:0] QN_B   = 64'hFFF8_0000_0000_0055;
   localparam logic [63:0] SN_A   = 64'h7FFC_0000_0000_0ABC;
   localparam logic [63:0] SN_B   = 64'hFFFC_0000_0000_0077;
   localparam logic [63:0] NO_A   = 64'h7FF4_0000_0000_0042;
   localparam logic [63:0] NO_B   = 64'hFFF4_0000_0000_0099;
   localparam logic [63:0] DQN    = 64'h7FF8_0000_0000_0000;

   localparam int NV = 25;
   // {op_mul, a, b, exp_valid, exp_result, exp_invalid}
   localparam logic [194:0] VEC [NV] = '{
      {1'b0, ONE,   TWO_N, 1'b0, ZER_P,                 1'b0},
      {1'b1, DEN,   ZER_N, 1'b0, ZER_P,                 1'b0},
      {1'b0, QN_A,  ONE,   1'b1, QN_A,                  1'b0},
      {1'b1, ONE,   QN_B,  1'b1, QN_B,                  1'b0},
      {1'b0, SN_A,  ONE,   1'b1, SN_A,                  1'b1},
      {1'b1, QN_A,  NO_B,  1'b1, QN_A,                  1'b0},
      {1'b0, INF_P, QN_B,  1'b1, QN_B,                  1'b0},
      {1'b0, QN_A,  QN_B,  1'b1, QN_A,                  1'b0},
      {1'b1, QN_B,  SN_A,  1'b1, 64'hFFF8_0000_0000_0055, 1'b1},
      {1'b0, SN_A,  SN_B,  1'b1, 64'h7FF8_0000_0000_0ABC, 1'b1},
      {1'b0, NO_A,  TWO_N, 1'b1, TWO_N,                 1'b0},
      {1'b1, TWO_N, NO_B,  1'b1, TWO_N,                 1'b0},
      {1'b1, NO_A,  INF_N, 1'b1, INF_N,                 1'b0},
      {1'b0, NO_B,  ZER_N, 1'b1, ZER_N,                 1'b0},
      {1'b0, NO_A,  NO_B,  1'b1, NO_A,                  1'b0},
      {1'b1, NO_B,  NO_A,  1'b1, NO_B,                  1'b0},
      {1'b0, INF_P, INF_N, 1'b1, DQN,                   1'b1},
      {1'b0, INF_P, INF_P0,1'b1, INF_P,                 1'b0},
      {1'b0, ONE,   INF_N, 1'b1, INF_N,                 1'b0},
      {1'b1, INF_P, ZER_N, 1'b1, DQN,                   1'b1},
      {1'b1, ZER_P, INF_N, 1'b1, DQN,                   1'b1},
      {1'b1, INF_P, TWO_N, 1'b1, 64'hFFF0_0000_0000_0007, 1'b0},
      {1'b1, INF_N, INF_N, 1'b1, 64'h7FF0_0000_0000_0009, 1'b0},
      {1'b1, DEN,   INF_P, 1'b1, INF_P,                 1'b0},
      {1'b0, INF_N, INF_N, 1'b1, INF_N,                 1'b0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_mul = 1'b0;
   logic [63:0] opnd_a = '0;
   logic [63:0] opnd_b = '0;
   logic        spec_valid;
   logic [63:0] spec_result;
   logic        invalid_flag;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   string tag_tbl [NV];

   always #4 clk = ~clk;   // 125 MHz

   fpsp_top u_dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .op_mul       (op_mul),
      .opnd_a       (opnd_a),
      .opnd_b       (opnd_b),
      .spec_valid   (spec_valid),
      .spec_result  (spec_result),
      .invalid_flag (invalid_flag)
   );

   task automatic check(input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #200000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      tag_tbl = '{"R2", "R2", "R3", "R3", "R3_R5", "R3", "R3", "R4", "R4_R5", "R4",
                  "R6", "R6", "R6", "R6", "R7", "R7", "R8", "R8", "R8", "R9",
                  "R9", "R10", "R10", "R10", "R8"};

      // R11: outputs held at zero under reset, even with special inputs
      opnd_a = INF_P; opnd_b = ZER_N; op_mul = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R11", "valid in reset",   {63'd0, spec_valid},   64'd0);
      check("R11", "result in reset",  spec_result,           64'd0);
      check("R11", "invalid in reset", {63'd0, invalid_flag}, 64'd0);
      rst_n = 1'b1;

      // Table walk: drive on the falling edge, sample one cycle later
      for (int i = 0; i < NV; i++) begin
         logic [194:0] v;
         v = VEC[i];
         op_mul = v[194];
         opnd_a = v[193:130];
         opnd_b = v[129:66];
         @(posedge clk);
         @(negedge clk);
         check(tag_tbl[i], $sformatf("vec %0d valid", i), {63'd0, spec_valid}, {63'd0, v[65]});
         if (v[65])
            check(tag_tbl[i], $sformatf("vec %0d result", i), spec_result, v[64:1]);
         // R12: invalid only where R5, R8 or R9 call for it
         check(tag_tbl[i], $sformatf("vec %0d invalid", i), {63'd0, invalid_flag}, {63'd0, v[0]});
      end

      // R1: exponent one below all-ones is finite, so no special result
      op_mul = 1'b0; opnd_a = 64'h7FEC_0000_0000_0ABC; opnd_b = ONE;
      @(posedge clk); @(negedge clk);
      check("R1", "near-max exponent valid", {63'd0, spec_valid}, 64'd0);

      // R1/R6: None with all-zero payload still acts as identity in multiply
      op_mul = 1'b1; opnd_a = 64'h7FF4_0000_0000_0000; opnd_b = DEN;
      @(posedge clk); @(negedge clk);
      check("R6", "none zero payload", spec_result, DEN);

      // R5: signalling NaN beside None raises invalid, NaN kept (R3)
      op_mul = 1'b0; opnd_a = NO_A; opnd_b = SN_B;
      @(posedge clk); @(negedge clk);
      check("R5", "snan with none invalid", {63'd0, invalid_flag}, 64'd1);
      check("R3", "snan with none result", spec_result, SN_B);

      // R11: asynchronous reset clears a registered invalid result
      op_mul = 1'b1; opnd_a = INF_N; opnd_b = ZER_P;
      @(posedge clk);
      #2;
      rst_n = 1'b0;
      #1;
      check("R11", "async clear valid",   {63'd0, spec_valid},   64'd0);
      check("R11", "async clear invalid", {63'd0, invalid_flag}, 64'd0);
      check("R11", "async clear result",  spec_result,           64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R9", "after reset inf*0", spec_result, DQN);

      finish_run();
   end

endmodule